// File: doc/BRIEF.md
# Bidirectional Port Register Bank

This block holds four byte-wide general-purpose I/O ports behind a small register bus. Each port has an output latch and a direction register. A direction bit of 1 makes that pin an output and a direction bit of 0 makes it an input. A bus master writes the latches and direction registers with a single-cycle write strobe. It reads them back through a registered read-data path. When a port's data location is read, the value is assembled bit by bit: input bits come from the external pins and output bits come from the latch.

The address map is sparse. Data and direction locations come in pairs, with data at the even offset and direction at the odd offset. The pairs start at 0xE0, 0xE2, 0xE4 and 0xE8, which select ports 0, 1, 2 and 3. The pair at 0xE6 is a hole. For every port, the block drives the latch value on output bits and drives a constant 1 on input bits. Input pins are pulled high, not released.

Top module: `gpio_bank_top`

## Requirements
- R1: During and after a synchronous reset, all latches and direction registers are 0x00. Every `pin_drive` bit is therefore 1, and `bus_rdata` is 0x00.
- R2: A write with `bus_wr`=1 changes one register only. Offsets 0xE0, 0xE2, 0xE4 and 0xE8 address the output latch of ports 0, 1, 2 and 3. Offsets 0xE1, 0xE3, 0xE5 and 0xE9 address the direction register of the same ports. No other port's registers change.
- R3: Reading a direction offset returns the stored direction byte unchanged.
- R4: Reading a data offset returns (pin & ~dir) | (latch & dir) for that port, where pin is the `pin_in` byte in the cycle of the read.
- R5: Port p drives `pin_drive[8p+7:8p]` = latch | ~dir. The new value appears in the cycle after the clock edge that takes a latch or direction write.
- R6: Every offset not listed in R2 reads as 0xFF. This includes 0xE6, 0xE7 and addresses outside 0xE0..0xE9. A write to such an offset changes no latch, no direction register and no `pin_drive` bit.
- R7: `bus_rdata` is registered and shows the location addressed in the previous cycle. A read in the same cycle as a write to that location returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 32 | Pin levels, port p in bits 8p+7..8p |
| pin_drive | output | 32 | Pin drive values, port p in bits 8p+7..8p |

## Verification
A write is taken at a rising edge. Its effect on `pin_drive` is due one cycle later, and the testbench samples it on the following falling edge. Read data is due at the first rising edge after the address is applied, using the `pin_in` value present at that edge. The testbench holds the address and pins steady across that edge and compares on the next falling edge. For a read that coincides with a write, the expected value is computed before the testbench model takes the write, which checks the old-value rule.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  // Number of two-byte slots in the window; slot 3 is a hole.
  localparam int SLOT_COUNT = 5;
  localparam logic [2:0] NO_PORT = 3'd7;

  // Non-linear slot to port mapping.
  function automatic logic [2:0] slot_to_port(input logic [2:0] slot);
    case (slot)
      3'd0:    return 3'd0;
      3'd1:    return 3'd1;
      3'd2:    return 3'd2;
      3'd4:    return 3'd3;
      default: return NO_PORT;
    endcase
  endfunction
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W = 2,
  parameter logic [ADDR_W-1:0] BASE = 8'hE0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic              is_dir,
  output logic [IDX_W-1:0]  idx
);
  localparam int WIN = 2 * SLOT_COUNT;

  logic [ADDR_W-1:0] offs;
  logic [2:0]        port;

  always_comb begin
    offs   = addr - BASE;
    port   = slot_to_port(offs[3:1]);
    hit    = (offs < ADDR_W'(WIN)) && (port != NO_PORT);
    is_dir = offs[0];
    idx    = port[IDX_W-1:0];
  end
endmodule

// File: rtl/gpio_port_slice.sv
module gpio_port_slice #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_lat,
  input  logic         wr_dir,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] view,
  output logic [W-1:0] drive
);
  logic [W-1:0] lat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q <= '0;
      dir_q <= '0;
    end else begin
      if (wr_lat) lat_q <= wdata;
      if (wr_dir) dir_q <= wdata;
    end
  end

  always_comb begin
    view  = (pin_in & ~dir_q) | (lat_q & dir_q);
    drive = lat_q | ~dir_q;
  end

  assert_dir_load_R2: assert property (@(posedge clk) disable iff (rst)
    wr_dir |=> dir_q == $past(wdata));

  assert_drive_follow_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_lat && !wr_dir) |=> ((drive & dir_q) == ($past(wdata) & dir_q)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!wr_lat && !wr_dir) |=> ($stable(dir_q) && $stable(drive)));
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux #(
  parameter int PORTS = 4,
  parameter int W = 8,
  parameter int IDX_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PORTS*W-1:0] views,
  input  logic [PORTS*W-1:0] dirs,
  input  logic               hit,
  input  logic               is_dir,
  input  logic [IDX_W-1:0]   idx,
  output logic [W-1:0]       rdata
);
  logic [W-1:0] sel;

  always_comb begin
    sel = '1;
    if (hit) sel = is_dir ? dirs[idx*W +: W] : views[idx*W +: W];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= sel;
  end
endmodule

// File: rtl/gpio_bank_top.sv
module gpio_bank_top #(
  parameter int PORTS = 4,
  parameter int W = 8,
  parameter int ADDR_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [W-1:0]       bus_wdata,
  output logic [W-1:0]       bus_rdata,
  input  logic [PORTS*W-1:0] pin_in,
  output logic [PORTS*W-1:0] pin_drive
);
  localparam int IDX_W = $clog2(PORTS);

  logic             hit, is_dir;
  logic [IDX_W-1:0] idx;
  logic [PORTS*W-1:0] views, dirs;

  gpio_addr_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
    .addr(bus_addr), .hit(hit), .is_dir(is_dir), .idx(idx)
  );

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic sel_p;
    assign sel_p = bus_wr && hit && (idx == IDX_W'(p));
    gpio_port_slice #(.W(W)) u_slice (
      .clk(clk), .rst(rst),
      .wr_lat(sel_p && !is_dir), .wr_dir(sel_p && is_dir),
      .wdata(bus_wdata), .pin_in(pin_in[p*W +: W]),
      .dir_q(dirs[p*W +: W]), .view(views[p*W +: W]),
      .drive(pin_drive[p*W +: W])
    );
  end

  gpio_read_mux #(.PORTS(PORTS), .W(W), .IDX_W(IDX_W)) u_rmux (
    .clk(clk), .rst(rst), .views(views), .dirs(dirs),
    .hit(hit), .is_dir(is_dir), .idx(idx), .rdata(bus_rdata)
  );

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (pin_drive == '1) && (bus_rdata == '0));

  assert_unmapped_R6: assert property (@(posedge clk) disable iff (rst)
    !hit |=> bus_rdata == '1);

  assert_dir_read_R3: assert property (@(posedge clk) disable iff (rst)
    (hit && is_dir && !bus_wr) |=> bus_rdata == $past(dirs[idx*W +: W]));
endmodule

// File: tb/test_gpio_bank_top.sv
`timescale 1ns/1ps
module test_gpio_bank_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic [31:0] pin_in = 32'h0;
  logic [31:0] pin_drive;

  int checks = 0;
  int fails = 0;
  logic [7:0] m_lat [4];
  logic [7:0] m_dir [4];

  always #2.5 clk = ~clk;

  gpio_bank_top i_gpio_bank_top (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_drive(pin_drive)
  );

  // Returns port number or -1; sets d when the offset is a direction one.
  function automatic int port_of(input logic [7:0] a, output bit d);
    d = a[0];
    case (a)
      8'hE0, 8'hE1: return 0;
      8'hE2, 8'hE3: return 1;
      8'hE4, 8'hE5: return 2;
      8'hE8, 8'hE9: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic logic [7:0] exp_read(input logic [7:0] a, input logic [31:0] pins);
    bit d;
    int p;
    p = port_of(a, d);
    if (p < 0) return 8'hFF;
    if (d) return m_dir[p];
    return (pins[p*8 +: 8] & ~m_dir[p]) | (m_lat[p] & m_dir[p]);
  endfunction

  function automatic logic [31:0] exp_drive();
    logic [31:0] r;
    for (int p = 0; p < 4; p++) r[p*8 +: 8] = m_lat[p] | ~m_dir[p];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [7:0] a, input logic [31:0] pins, input string req);
    logic [7:0] e;
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0; pin_in = pins;
    e = exp_read(a, pins);
    @(negedge clk);
    check(req, {24'h0, bus_rdata}, {24'h0, e});
  endtask

  // Write; also checks the same-cycle read returns the old value (R7)
  task automatic do_write(input logic [7:0] a, input logic [7:0] v);
    logic [7:0] old;
    bit d;
    int p;
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = v;
    old = exp_read(a, pin_in);
    @(posedge clk);
    p = port_of(a, d);
    if (p >= 0) begin
      if (d) m_dir[p] = v; else m_lat[p] = v;
    end
    @(negedge clk);
    bus_wr = 1'b0;
    check("R7 read during write", {24'h0, bus_rdata}, {24'h0, old});
    check("R5 drive after write", pin_drive, exp_drive());
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] maps [8];
    maps = '{8'hE0, 8'hE1, 8'hE2, 8'hE3, 8'hE4, 8'hE5, 8'hE8, 8'hE9};
    void'($urandom(32'h5EED));
    for (int p = 0; p < 4; p++) begin m_lat[p] = 8'h00; m_dir[p] = 8'h00; end
    repeat (3) @(negedge clk);
    check("R1 reset drive", pin_drive, 32'hFFFF_FFFF);
    check("R1 reset rdata", {24'h0, bus_rdata}, 32'h0);
    rst = 1'b0;
    // R1: all inputs after reset, so data reads return the pins
    do_read(8'hE0, 32'h1234_5678, "R1 R4 port0 input");
    do_read(8'hE9, 32'h0, "R1 R3 dir3 zero");
    // R2 directed: each location, distinct values
    do_write(8'hE0, 8'hA5); do_write(8'hE1, 8'hF0);
    do_write(8'hE2, 8'h3C); do_write(8'hE3, 8'h0F);
    do_write(8'hE4, 8'h81); do_write(8'hE5, 8'hFF);
    do_write(8'hE8, 8'h5A); do_write(8'hE9, 8'h00);
    for (int i = 0; i < 8; i++) do_read(maps[i], 32'hC3C3_C3C3, "R2 R3 R4 directed map");
    // R6: holes and outside addresses read 0xFF and writes do nothing
    do_read(8'hE6, 32'h0, "R6 hole E6");
    do_read(8'hE7, 32'h0, "R6 hole E7");
    do_read(8'hEA, 32'h0, "R6 EA");
    do_read(8'h00, 32'h0, "R6 low");
    do_write(8'hE6, 8'h00); do_write(8'hE7, 8'hFF); do_write(8'hDF, 8'h77);
    for (int i = 0; i < 8; i++) do_read(maps[i], 32'h0F0F_0F0F, "R6 no effect");
    // R4 corner: all-output and all-input on port1
    do_write(8'hE3, 8'hFF);
    do_read(8'hE2, 32'h0000_FF00 ^ 32'hFFFF_FFFF, "R4 all output");
    do_write(8'hE3, 8'h00);
    do_read(8'hE2, 32'h0000_9900, "R4 all input");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      int r;
      r = int'($urandom_range(0, 9));
      if (r < 7) a = maps[$urandom_range(0, 7)];
      else if (r < 9) a = 8'hE0 + 8'($urandom_range(0, 15));
      else a = 8'($urandom);
      if ($urandom_range(0, 1) == 0) do_write(a, 8'($urandom));
      else do_read(a, $urandom, "R2 R3 R4 R6 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule